// File: doc/BRIEF.md
# UART Interrupt Enable and Request Router

This block holds the interrupt and DMA enable bits of a serial port. It sends receiver and transmitter events to one interrupt line or to two DMA request lines. Software reaches the enables through two word registers. Writing to the set register turns on each enable whose data bit is 1. Writing to the clear register turns off each enable whose data bit is 1. Both registers read back the same enable state.

The receiver reports the status of a frame as a level, `rx_ready`, together with `rx_is_addr`. This flag tells whether the waiting frame is an address frame or a data frame in multiprocessor mode. Two enables decide where the frame goes. With receive DMA off, every frame goes to the interrupt line. With receive DMA on and the all-frames enable off, address frames interrupt and data frames request DMA. With both on, every frame requests DMA. A DMA request is a single-clock pulse for each new frame. The interrupt line is a level: the OR of all event levels, each gated by its enable.

Top module: `uart_irq_router`

## Requirements
- R1: After reset every enable is 0, both registers read 0, and `irq`, `rx_dma_req` and `tx_dma_req` are low.
- R2: The set register is at byte address 0x0C. Writing 1 to a bit sets that enable and writing 0 leaves it unchanged. The enable bit positions are: break 0, wakeup 1, transmit interrupt 8, receive interrupt 9, transmit DMA 16, receive DMA 17, receive DMA for all frames 18, parity 24, overrun 25, framing 26.
- R3: The clear register is at byte address 0x10. Writing 1 to a bit clears that enable and writing 0 leaves it unchanged. Reading it returns the same value as reading the set register.
- R4: All other bits read 0 and ignore writes. Any other address reads 0 and a write to it changes no enable.
- R5: A framing, overrun or parity error level drives `irq` only while its own enable is set.
- R6: A wakeup or break level drives `irq` only while its own enable is set.
- R7: With receive DMA disabled, `rx_ready` drives `irq` when the receive interrupt enable is set, for both frame kinds, and no receive DMA request is made.
- R8: With receive DMA enabled and the all-frames enable clear, an address frame drives `irq` (subject to the receive interrupt enable) and makes no DMA request. A data frame makes a DMA request and does not drive `irq`.
- R9: With receive DMA and the all-frames enable both set, address and data frames both make DMA requests and neither drives `irq`.
- R10: With transmit DMA enabled, `tx_ready` makes DMA requests and does not drive `irq`. With transmit DMA disabled, `tx_ready` drives `irq` when the transmit interrupt enable is set.
- R11: Each DMA request is a pulse of exactly one clock. It is high in the cycle after the clock edge that first samples the rising ready level, and it does not repeat while the level stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| ev_frame_err | input | 1 | Framing error level |
| ev_overrun | input | 1 | Overrun error level |
| ev_parity | input | 1 | Parity error level |
| ev_wakeup | input | 1 | Wakeup level |
| ev_break | input | 1 | Break detect level |
| rx_ready | input | 1 | Received frame waiting |
| rx_is_addr | input | 1 | Waiting frame is an address frame |
| tx_ready | input | 1 | Transmitter can accept data |
| irq | output | 1 | Interrupt request level |
| rx_dma_req | output | 1 | Receive DMA request pulse |
| tx_dma_req | output | 1 | Transmit DMA request pulse |

## Verification
The hardest cases are the steering decisions for received frames. They depend on the receive interrupt enable, the receive DMA enable, the all-frames enable and the frame kind all at once. The bench first wipes all enables through the clear register and then loads each of the sixteen combinations. For each one it raises `rx_ready`, checks the interrupt level at once, then checks the DMA line on the first and the second clock after the rise. This confirms that the pulse lasts one clock while the level stays high.

// File: rtl/uart_irq_router.sv
module uart_irq_router #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SET_OFS = 8'h0C,
  parameter logic [ADDR_W-1:0] CLR_OFS = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ev_frame_err,
  input  logic              ev_overrun,
  input  logic              ev_parity,
  input  logic              ev_wakeup,
  input  logic              ev_break,
  input  logic              rx_ready,
  input  logic              rx_is_addr,
  input  logic              tx_ready,
  output logic              irq,
  output logic              rx_dma_req,
  output logic              tx_dma_req
);
  localparam int B_BRK = 0, B_WAKE = 1, B_TXI = 8, B_RXI = 9;
  localparam int B_TXD = 16, B_RXD = 17, B_RXALL = 18;
  localparam int B_PE = 24, B_OE = 25, B_FE = 26;
  localparam logic [31:0] MASK = (32'd1 << B_BRK) | (32'd1 << B_WAKE) |
    (32'd1 << B_TXI) | (32'd1 << B_RXI) | (32'd1 << B_TXD) | (32'd1 << B_RXD) |
    (32'd1 << B_RXALL) | (32'd1 << B_PE) | (32'd1 << B_OE) | (32'd1 << B_FE);

  logic [31:0] en;
  logic rx_prev, tx_prev;

  wire set_hit = bus_we && (bus_addr == SET_OFS);
  wire clr_hit = bus_we && (bus_addr == CLR_OFS);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en <= '0;
    else if (clr_hit) en <= en & ~bus_wdata;
    else if (set_hit) en <= en | (bus_wdata & MASK);

  assign bus_rdata = (bus_addr == SET_OFS || bus_addr == CLR_OFS) ? en : 32'd0;

  wire rx_to_irq = en[B_RXD] ? (!en[B_RXALL] && rx_is_addr) : 1'b1;
  wire rx_to_dma = en[B_RXD] && (en[B_RXALL] || !rx_is_addr);

  assign irq = (ev_frame_err & en[B_FE]) | (ev_overrun & en[B_OE]) |
               (ev_parity & en[B_PE]) | (ev_wakeup & en[B_WAKE]) |
               (ev_break & en[B_BRK]) |
               (rx_ready & en[B_RXI] & rx_to_irq) |
               (tx_ready & en[B_TXI] & !en[B_TXD]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_prev <= 1'b0; tx_prev <= 1'b0;
      rx_dma_req <= 1'b0; tx_dma_req <= 1'b0;
    end else begin
      rx_prev <= rx_ready; tx_prev <= tx_ready;
      rx_dma_req <= rx_ready && !rx_prev && rx_to_dma;
      tx_dma_req <= tx_ready && !tx_prev && en[B_TXD];
    end

  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && !clr_hit) |=> ((en & $past(bus_wdata & MASK)) == $past(bus_wdata & MASK)));
  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> ((en & $past(bus_wdata)) == 32'd0));
  a_r4_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(en));
  a_r11_rx_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |=> !rx_dma_req);
  a_r11_tx_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |=> !tx_dma_req);
  a_r9_rx_dma_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> $past(en[B_RXD]));
  a_r10_tx_dma_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> $past(en[B_TXD]));
endmodule

// File: tb/sim_uart_irq_router.sv
`timescale 1ns/1ps
module sim_uart_irq_router;
  localparam logic [31:0] MASK = 32'h0707_0303;
  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic fe = 0, oe = 0, pe = 0, wk = 0, bk = 0, rxr = 0, rxa = 0, txr = 0;
  logic irq, rxd, txd;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  uart_irq_router u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_frame_err(fe), .ev_overrun(oe),
    .ev_parity(pe), .ev_wakeup(wk), .ev_break(bk), .rx_ready(rxr), .rx_is_addr(rxa),
    .tx_ready(txr), .irq(irq), .rx_dma_req(rxd), .tx_dma_req(txd));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0; bus_wdata = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a; #1; chk(tag, bus_rdata, exp);
  endtask

  task automatic load(input logic [31:0] v);
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h0C, v);
  endtask

  initial begin
    #200000; chk("watchdog", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rd("R1 reset set reg", 8'h0C, 0);
    rd("R1 reset clear reg", 8'h10, 0);
    chk("R1 reset outputs", {irq, rxd, txd}, 0);
    rst_n = 1;
    fe = 1; oe = 1; pe = 1; wk = 1; bk = 1; rxr = 1; txr = 1; #1;
    chk("R1 irq low with no enables", irq, 0);
    @(negedge clk); chk("R1 no dma with no enables", {rxd, txd}, 0);
    fe = 0; oe = 0; pe = 0; wk = 0; bk = 0; rxr = 0; txr = 0;

    for (int i = 0; i < 32; i++) begin
      wr(8'h0C, 32'd1 << i);
      rd("R2 R4 single-bit set", 8'h0C, (32'd1 << i) & MASK);
      rd("R3 clear reg mirrors", 8'h10, (32'd1 << i) & MASK);
      wr(8'h10, 32'hFFFF_FFFF);
    end
    wr(8'h0C, 32'hFFFF_FFFF);
    rd("R4 all ones reads mask", 8'h0C, MASK);
    wr(8'h0C, 32'h0);
    rd("R2 zero write keeps", 8'h0C, MASK);
    for (int i = 0; i < 32; i++) begin
      wr(8'h10, 32'd1 << i);
      rd("R3 single-bit clear", 8'h0C, MASK & ~(32'd1 << i));
      wr(8'h0C, 32'hFFFF_FFFF);
    end
    wr(8'h10, 32'h0);
    rd("R3 zero clear keeps", 8'h10, MASK);
    wr(8'h10, MASK);
    wr(8'h14, 32'hFFFF_FFFF);
    rd("R4 other address ignored", 8'h0C, 0);
    rd("R4 other address reads 0", 8'h14, 0);

    for (int s = 0; s < 5; s++) begin
      int bitp;
      bitp = (s == 0) ? 26 : (s == 1) ? 25 : (s == 2) ? 24 : (s == 3) ? 1 : 0;
      for (int e = 0; e < 2; e++) begin
        load(e ? (32'd1 << bitp) : (MASK & ~(32'd1 << bitp)));
        @(negedge clk);
        fe = (s == 0); oe = (s == 1); pe = (s == 2); wk = (s == 3); bk = (s == 4); #1;
        chk(s < 3 ? "R5 error gate" : "R6 wake/break gate", irq, e[0]);
        fe = 0; oe = 0; pe = 0; wk = 0; bk = 0;
      end
    end

    for (int c = 0; c < 16; c++) begin
      logic ie, de, al, ad, exp_irq, exp_dma;
      string tag;
      ie = c[0]; de = c[1]; al = c[2]; ad = c[3];
      exp_irq = ie & (!de | (!al & ad));
      exp_dma = de & (al | !ad);
      tag = !de ? "R7 rx no dma" : (al ? "R9 rx all dma" : "R8 rx split");
      load({13'd0, al, de, 7'd0, ie, 9'd0});
      @(negedge clk); rxa = ad; rxr = 1; #1;
      chk(tag, irq, exp_irq);
      @(posedge clk); #1; chk(tag, rxd, exp_dma);
      @(posedge clk); #1; chk("R11 rx single pulse", rxd, 0);
      chk(tag, irq, exp_irq);
      @(negedge clk); rxr = 0;
      @(negedge clk);
    end

    for (int c = 0; c < 4; c++) begin
      logic ie, de;
      ie = c[0]; de = c[1];
      load({15'd0, de, 7'd0, ie, 8'd0});
      @(negedge clk); txr = 1; #1;
      chk("R10 tx irq", irq, ie & !de);
      @(posedge clk); #1; chk("R10 tx dma", txd, de);
      @(posedge clk); #1; chk("R11 tx single pulse", txd, 0);
      @(negedge clk); txr = 0;
      @(negedge clk);
    end

    load(32'h0002_0000);
    @(negedge clk); rxa = 0; rxr = 1;
    repeat (2) @(negedge clk); rxr = 0;
    @(negedge clk); rxr = 1; #1;
    @(posedge clk); #1; chk("R11 second frame pulses again", rxd, 1);
    @(negedge clk); rxr = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule